// File: doc/BRIEF.md
# Two-Sided Interprocessor Mailbox

This block is a register-mapped mailbox shared by two processors, called user 0 and user 1. Each user has its own 32-bit register port: a request strobe, a write flag, a 12-bit byte address and write data, with read data returned combinationally in the same cycle. The mailbox holds a set of one-way message channels, eight by default. Each channel is a small word FIFO, four words deep by default. A per-channel direction setting chooses which user may push into the channel and which user may pop from it. The direction can be changed at run time.

Each user has its own interrupt-enable and interrupt-status registers. Receive and transmit bits alternate in these registers. A user can also read the peer's enable and status through a read-only peer view. A sender polls the peer view to see that the receiver has drained and acknowledged a channel. Each user's interrupt line is high while any of its status bits and its matching enable bit are both set.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every channel is empty (count 0, full 0), both enable and both status registers read 0, all direction fields are 0 (every channel goes from user 0 to user 0), and both interrupt lines are low.
- R2: The direction fields are read and written by both users. Channels 0-3 are at byte offset 0x000 and channels 4-7 at 0x004, one byte per channel, with channel n in byte n mod 4. Bit 0 of the byte is the receiving user and bit 4 is the sending user; all other bits read 0. Writing 0x01100110 to both words makes even channels go from user 1 to user 0 and odd channels from user 0 to user 1.
- R3: A write to 0x180+4n by channel n's sending user pushes the word if the FIFO is not full. A write to a full channel, or a write by the other user, changes nothing.
- R4: A read of 0x180+4n by channel n's receiving user returns the oldest word and removes it. A read of an empty channel, or a read by the other user, returns 0 and removes nothing.
- R5: Address 0x100+4n bit 0 reads 1 exactly when channel n holds the full depth. Address 0x140+4n returns the number of queued words in bits [2:0]. Both users read the same values.
- R6: The status register is at 0x050. Status bit 2n of channel n's receiver is set one cycle after the channel becomes non-empty. It stays set while the channel holds words, even if a one is written to it. Once the channel is empty, writing a one to the bit clears it.
- R7: Status bit 2n+1 of channel n's sender is set on each successful pop from channel n. Writing a one to the bit clears it, but a new pop in the same cycle keeps it set.
- R8: The enable register is at 0x040. Each interrupt line is high exactly when the AND of that user's status and enable registers is nonzero.
- R9: Offsets 0x060 and 0x070 return the peer's enable and status registers. Writes to these offsets change nothing.
- R10: When a push and a pop reach one channel in the same cycle, the pop is served. The push is accepted only if the channel was not full before that cycle, so a full channel ends the cycle one word short of full.
- R11: When both users write the same direction word in one cycle, user 1's value is kept.
- R12: An access whose address bits [1:0] are not zero, or whose address is unmapped, reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| u0_req | input | 1 | User 0 access strobe |
| u0_we | input | 1 | User 0 write (1) or read (0) |
| u0_addr | input | 12 | User 0 byte address |
| u0_wdata | input | 32 | User 0 write data |
| u0_rdata | output | 32 | User 0 read data, same cycle |
| u0_irq | output | 1 | User 0 interrupt |
| u1_req | input | 1 | User 1 access strobe |
| u1_we | input | 1 | User 1 write (1) or read (0) |
| u1_addr | input | 12 | User 1 byte address |
| u1_wdata | input | 32 | User 1 write data |
| u1_rdata | output | 32 | User 1 read data, same cycle |
| u1_irq | output | 1 | User 1 interrupt |

## Verification
Two functions can meet in one cycle: a push from the sender and a pop from the receiver on the same channel, and a write-one-to-clear on a status bit while the same bit is being set. The bench drives both ports in the same cycle on purpose. In one directed case the sender pushes into a full channel while the receiver pops; the bench expects the oldest word back and a count one below full. Random dual-port traffic then reaches both meetings again, and every read value and interrupt line is compared against a bench model that applies pops before pushes and sets before clears.

// File: rtl/ipc_mbx_pkg.sv
`timescale 1ns/1ps
package ipc_mbx_pkg;

   typedef enum logic [3:0] {
      RG_NONE, RG_CTRL, RG_EN, RG_STAT, RG_PEER_EN, RG_PEER_STAT,
      RG_FULL, RG_COUNT, RG_DATA
   } region_e;

   typedef struct packed {
      region_e    rg;
      logic [3:0] idx;
   } decode_t;

   localparam logic [11:0] OFS_EN        = 12'h040;
   localparam logic [11:0] OFS_STAT      = 12'h050;
   localparam logic [11:0] OFS_PEER_EN   = 12'h060;
   localparam logic [11:0] OFS_PEER_STAT = 12'h070;
   localparam logic [5:0]  BLK_CTRL      = 6'h00;
   localparam logic [5:0]  BLK_FULL      = 6'h04;
   localparam logic [5:0]  BLK_COUNT     = 6'h05;
   localparam logic [5:0]  BLK_DATA      = 6'h06;

   function automatic decode_t decode_addr(input logic [11:0] addr);
      decode_t d;
      d.idx = addr[5:2];
      d.rg  = RG_NONE;
      if (addr[1:0] == 2'b00) begin
         if (addr[11:6] == BLK_CTRL)        d.rg = RG_CTRL;
         else if (addr == OFS_EN)           d.rg = RG_EN;
         else if (addr == OFS_STAT)         d.rg = RG_STAT;
         else if (addr == OFS_PEER_EN)      d.rg = RG_PEER_EN;
         else if (addr == OFS_PEER_STAT)    d.rg = RG_PEER_STAT;
         else if (addr[11:6] == BLK_FULL)   d.rg = RG_FULL;
         else if (addr[11:6] == BLK_COUNT)  d.rg = RG_COUNT;
         else if (addr[11:6] == BLK_DATA)   d.rg = RG_DATA;
      end
      return d;
   endfunction

endpackage

// File: rtl/ipc_mbx_fifo.sv
`timescale 1ns/1ps
module ipc_mbx_fifo #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CW   = $clog2(DEPTH + 1),
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full
);

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("ipc_mbx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] count_q;
   logic          push_ok, pop_ok;

   assign full    = (count_q == CW'(DEPTH));
   assign pop_ok  = pop && (count_q != '0);
   assign push_ok = push && !full;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr  <= '0;
         wr_ptr  <= '0;
         count_q <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         unique case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign head  = (count_q == '0) ? '0 : mem[rd_ptr];
   assign count = count_q;

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));
   assert_full_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count_q == $past(count_q)));
   assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((count_q == '0) && pop && !push) |=> (count_q == '0));
   assert_full_pushpop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && pop) |=> (count_q == CW'(DEPTH - 1)));

endmodule

// File: rtl/ipc_mbx_irq.sv
`timescale 1ns/1ps
module ipc_mbx_irq #(
   parameter int unsigned NCH = 8,
   localparam int unsigned SW = 2 * NCH
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] rx_level,
   input  logic [NCH-1:0] tx_done,
   input  logic           en_we,
   input  logic           stat_we,
   input  logic [SW-1:0]  wdata,
   output logic [SW-1:0]  en,
   output logic [SW-1:0]  stat,
   output logic           irq
);

   logic [SW-1:0] set_v, rx_part, clr_v, en_q, stat_q;

   for (genvar n = 0; n < NCH; n++) begin : g_lane
      assign set_v[2*n]     = rx_level[n];
      assign set_v[2*n+1]   = tx_done[n];
      assign rx_part[2*n]   = rx_level[n];
      assign rx_part[2*n+1] = 1'b0;
   end

   assign clr_v = stat_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         stat_q <= '0;
      end else begin
         if (en_we) en_q <= wdata;
         stat_q <= (stat_q & ~clr_v) | set_v;
      end
   end

   assign en   = en_q;
   assign stat = stat_q;
   assign irq  = |(stat_q & en_q);

   assert_rx_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|rx_level) |=> ((stat_q & $past(rx_part)) == $past(rx_part)));
   assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we |=> ((stat_q & $past(wdata & ~set_v)) == '0));

endmodule

// File: rtl/ipc_mailbox.sv
`timescale 1ns/1ps
module ipc_mailbox #(
   parameter int unsigned NCH   = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        u0_req,
   input  logic        u0_we,
   input  logic [11:0] u0_addr,
   input  logic [31:0] u0_wdata,
   output logic [31:0] u0_rdata,
   output logic        u0_irq,
   input  logic        u1_req,
   input  logic        u1_we,
   input  logic [11:0] u1_addr,
   input  logic [31:0] u1_wdata,
   output logic [31:0] u1_rdata,
   output logic        u1_irq
);
   import ipc_mbx_pkg::*;

   localparam int unsigned DW = 32;
   localparam int unsigned SW = 2 * NCH;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("ipc_mailbox: NCH must be between 1 and 16");
   end
   if (CW > DW) begin : g_bad_cw
      $error("ipc_mailbox: DEPTH too large for the count field");
   end

   logic          req_a   [2];
   logic          we_a    [2];
   logic [11:0]   addr_a  [2];
   logic [DW-1:0] wdata_a [2];
   logic [DW-1:0] rdata_a [2];
   logic          irq_a   [2];
   decode_t       dec     [2];
   logic          ctrl_we [2];
   logic [NCH-1:0] wr_hit [2];
   logic [NCH-1:0] rd_hit [2];
   logic [SW-1:0]  en_v   [2];
   logic [SW-1:0]  stat_v [2];

   logic [NCH-1:0] rx_sel, tx_sel;
   logic [NCH-1:0] push_v, pop_v, pop_ok_v, full_v, busy_v;
   logic [DW-1:0]  head_v [NCH];
   logic [CW-1:0]  cnt_v  [NCH];

   assign req_a[0] = u0_req;   assign req_a[1] = u1_req;
   assign we_a[0]  = u0_we;    assign we_a[1]  = u1_we;
   assign addr_a[0] = u0_addr; assign addr_a[1] = u1_addr;
   assign wdata_a[0] = u0_wdata; assign wdata_a[1] = u1_wdata;
   assign u0_rdata = rdata_a[0]; assign u1_rdata = rdata_a[1];
   assign u0_irq = irq_a[0];     assign u1_irq = irq_a[1];

   // ---------------- direction fields: user 1 written last, so it wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sel <= '0;
         tx_sel <= '0;
      end else begin
         for (int u = 0; u < 2; u++) begin
            if (ctrl_we[u]) begin
               for (int n = 0; n < NCH; n++) begin
                  if (dec[u].idx == 4'(n / 4)) begin
                     rx_sel[n] <= wdata_a[u][8*(n%4)];
                     tx_sel[n] <= wdata_a[u][8*(n%4)+4];
                  end
               end
            end
         end
      end
   end

   // ---------------- channels
   for (genvar n = 0; n < NCH; n++) begin : g_ch
      assign push_v[n]   = tx_sel[n] ? wr_hit[1][n] : wr_hit[0][n];
      assign pop_v[n]    = rx_sel[n] ? rd_hit[1][n] : rd_hit[0][n];
      assign busy_v[n]   = (cnt_v[n] != '0);
      assign pop_ok_v[n] = pop_v[n] && busy_v[n];

      ipc_mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (push_v[n]),
         .pop   (pop_v[n]),
         .wdata (tx_sel[n] ? wdata_a[1] : wdata_a[0]),
         .head  (head_v[n]),
         .count (cnt_v[n]),
         .full  (full_v[n])
      );
   end

   // ---------------- per-user ports, interrupt banks and read muxes
   for (genvar u = 0; u < 2; u++) begin : g_usr
      localparam bit UB = (u == 1);
      localparam int unsigned PEER = 1 - u;
      logic [NCH-1:0] own_rx, own_tx;

      assign dec[u]     = decode_addr(addr_a[u]);
      assign ctrl_we[u] = req_a[u] && we_a[u] && (dec[u].rg == RG_CTRL);

      for (genvar n = 0; n < NCH; n++) begin : g_hit
         assign wr_hit[u][n] = req_a[u] && we_a[u] && (dec[u].rg == RG_DATA)
                               && (dec[u].idx == 4'(n));
         assign rd_hit[u][n] = req_a[u] && !we_a[u] && (dec[u].rg == RG_DATA)
                               && (dec[u].idx == 4'(n));
      end

      assign own_rx = UB ? rx_sel : ~rx_sel;
      assign own_tx = UB ? tx_sel : ~tx_sel;

      ipc_mbx_irq #(.NCH(NCH)) i_irq (
         .clk      (clk),
         .rst_n    (rst_n),
         .rx_level (own_rx & busy_v),
         .tx_done  (own_tx & pop_ok_v),
         .en_we    (req_a[u] && we_a[u] && (dec[u].rg == RG_EN)),
         .stat_we  (req_a[u] && we_a[u] && (dec[u].rg == RG_STAT)),
         .wdata    (wdata_a[u][SW-1:0]),
         .en       (en_v[u]),
         .stat     (stat_v[u]),
         .irq      (irq_a[u])
      );

      always_comb begin
         rdata_a[u] = '0;
         if (req_a[u] && !we_a[u]) begin
            unique case (dec[u].rg)
               RG_CTRL: begin
                  for (int n = 0; n < NCH; n++) begin
                     if (dec[u].idx == 4'(n / 4)) begin
                        rdata_a[u][8*(n%4)]   = rx_sel[n];
                        rdata_a[u][8*(n%4)+4] = tx_sel[n];
                     end
                  end
               end
               RG_EN:        rdata_a[u] = DW'(en_v[u]);
               RG_STAT:      rdata_a[u] = DW'(stat_v[u]);
               RG_PEER_EN:   rdata_a[u] = DW'(en_v[PEER]);
               RG_PEER_STAT: rdata_a[u] = DW'(stat_v[PEER]);
               RG_FULL: begin
                  for (int n = 0; n < NCH; n++)
                     if (dec[u].idx == 4'(n)) rdata_a[u] = DW'(full_v[n]);
               end
               RG_COUNT: begin
                  for (int n = 0; n < NCH; n++)
                     if (dec[u].idx == 4'(n)) rdata_a[u] = DW'(cnt_v[n]);
               end
               RG_DATA: begin
                  for (int n = 0; n < NCH; n++)
                     if (dec[u].idx == 4'(n) && (rx_sel[n] == UB))
                        rdata_a[u] = head_v[n];
               end
               default: rdata_a[u] = '0;
            endcase
         end
      end
   end

   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_we[0] || ctrl_we[1]) |=> ($stable(rx_sel) && $stable(tx_sel)));

endmodule

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic u0_req = 0, u0_we = 0, u1_req = 0, u1_we = 0;
   logic [11:0] u0_addr = '0, u1_addr = '0;
   logic [31:0] u0_wdata = '0, u1_wdata = '0;
   logic [31:0] u0_rdata, u1_rdata;
   logic u0_irq, u1_irq;

   always #4 clk = ~clk;   // 125 MHz

   ipc_mailbox i_ipc_mailbox (
      .clk(clk), .rst_n(rst_n),
      .u0_req(u0_req), .u0_we(u0_we), .u0_addr(u0_addr), .u0_wdata(u0_wdata),
      .u0_rdata(u0_rdata), .u0_irq(u0_irq),
      .u1_req(u1_req), .u1_we(u1_we), .u1_addr(u1_addr), .u1_wdata(u1_wdata),
      .u1_rdata(u1_rdata), .u1_irq(u1_irq)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [31:0] last_rd [2];

   // ---------------- bench model
   bit          m_rx [8], m_tx [8];
   logic [31:0] m_mem [8][4];
   int          m_hd [8], m_cnt [8];
   logic [15:0] m_en [2], m_st [2];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] lvl(input int u);
      logic [15:0] r = '0;
      for (int n = 0; n < 8; n++)
         if (int'(m_rx[n]) == u && m_cnt[n] > 0) r[2*n] = 1'b1;
      return r;
   endfunction

   function automatic string tag_of(input logic [11:0] a);
      if (a[1:0] != 2'b00) return "R12";
      if (a < 12'h040) return "R2";
      if (a == 12'h040) return "R8";
      if (a == 12'h050) return "R6";
      if (a == 12'h060 || a == 12'h070) return "R9";
      if (a[11:6] == 6'h04 || a[11:6] == 6'h05) return "R5";
      if (a[11:6] == 6'h06) return "R4";
      return "R12";
   endfunction

   function automatic logic [31:0] model_read(input int u, input logic [11:0] a);
      logic [31:0] r = '0;
      int n;
      n = int'(a[5:2]);
      if (a[1:0] != 2'b00) return '0;
      if (a < 12'h040) begin
         if (n < 2)
            for (int k = 0; k < 4; k++) begin
               r[8*k]   = m_rx[4*n+k];
               r[8*k+4] = m_tx[4*n+k];
            end
      end else if (a == 12'h040) r = 32'(m_en[u]);
      else if (a == 12'h050) r = 32'(m_st[u]);
      else if (a == 12'h060) r = 32'(m_en[1-u]);
      else if (a == 12'h070) r = 32'(m_st[1-u]);
      else if (n < 8) begin
         if (a[11:6] == 6'h04) r = (m_cnt[n] == 4) ? 32'd1 : 32'd0;
         else if (a[11:6] == 6'h05) r = 32'(m_cnt[n]);
         else if (a[11:6] == 6'h06 && int'(m_rx[n]) == u && m_cnt[n] > 0)
            r = m_mem[n][m_hd[n]];
      end
      return r;
   endfunction

   task automatic model_edge(input bit v [2], input bit w [2],
                             input logic [11:0] a [2], input logic [31:0] d [2]);
      logic [15:0] lb [2];
      logic [15:0] txs [2];
      bit pq [8], wq [8];
      logic [31:0] pd [8];
      for (int u = 0; u < 2; u++) begin lb[u] = lvl(u); txs[u] = '0; end
      for (int n = 0; n < 8; n++) begin pq[n] = 0; wq[n] = 0; pd[n] = '0; end
      for (int u = 0; u < 2; u++)
         if (v[u] && a[u][1:0] == 2'b00 && a[u][11:6] == 6'h06 && a[u][5:2] < 4'd8) begin
            int n = int'(a[u][5:2]);
            if (w[u] && int'(m_tx[n]) == u) begin wq[n] = 1; pd[n] = d[u]; end
            if (!w[u] && int'(m_rx[n]) == u) pq[n] = 1;
         end
      for (int n = 0; n < 8; n++) begin
         bit pok, wok;
         pok = pq[n] && m_cnt[n] > 0;
         wok = wq[n] && m_cnt[n] < 4;
         if (pok) begin
            m_hd[n] = (m_hd[n] + 1) % 4;
            m_cnt[n]--;
            txs[m_tx[n]][2*n+1] = 1'b1;
         end
         if (wok) begin
            m_mem[n][(m_hd[n] + m_cnt[n]) % 4] = pd[n];
            m_cnt[n]++;
         end
      end
      for (int u = 0; u < 2; u++) begin
         logic [15:0] clr = '0;
         if (v[u] && w[u] && a[u] < 12'h040 && a[u][1:0] == 2'b00 && a[u][5:2] < 4'd2) begin
            int k0 = 4 * int'(a[u][5:2]);
            for (int k = 0; k < 4; k++) begin
               m_rx[k0+k] = d[u][8*k];
               m_tx[k0+k] = d[u][8*k+4];
            end
         end
         if (v[u] && w[u] && a[u] == 12'h040) m_en[u] = d[u][15:0];
         if (v[u] && w[u] && a[u] == 12'h050) clr = d[u][15:0];
         m_st[u] = (m_st[u] & ~clr) | lb[u] | txs[u];
      end
   endtask

   // ---------------- stimulus
   task automatic step(input bit v0, input bit w0, input logic [11:0] a0, input logic [31:0] d0,
                       input bit v1, input bit w1, input logic [11:0] a1, input logic [31:0] d1);
      bit v [2], w [2];
      logic [11:0] a [2];
      logic [31:0] d [2];
      v[0] = v0; w[0] = w0; a[0] = a0; d[0] = d0;
      v[1] = v1; w[1] = w1; a[1] = a1; d[1] = d1;
      @(negedge clk);
      u0_req = v0; u0_we = w0; u0_addr = a0; u0_wdata = d0;
      u1_req = v1; u1_we = w1; u1_addr = a1; u1_wdata = d1;
      #1;
      chk("R8 irq0", 32'(u0_irq), 32'(|(m_st[0] & m_en[0])));
      chk("R8 irq1", 32'(u1_irq), 32'(|(m_st[1] & m_en[1])));
      if (v0 && !w0) begin last_rd[0] = u0_rdata; chk(tag_of(a0), u0_rdata, model_read(0, a0)); end
      if (v1 && !w1) begin last_rd[1] = u1_rdata; chk(tag_of(a1), u1_rdata, model_read(1, a1)); end
      @(posedge clk);
      model_edge(v, w, a, d);
      @(negedge clk);
      u0_req = 0; u0_we = 0; u1_req = 0; u1_we = 0;
      @(posedge clk);
      for (int u = 0; u < 2; u++) m_st[u] = m_st[u] | lvl(u);
      #2;
   endtask

   task automatic wr(input int u, input logic [11:0] a, input logic [31:0] d);
      if (u == 0) step(1, 1, a, d, 0, 0, '0, '0);
      else        step(0, 0, '0, '0, 1, 1, a, d);
   endtask

   task automatic rdx(input int u, input logic [11:0] a, input logic [31:0] exp, input string tag);
      if (u == 0) step(1, 0, a, '0, 0, 0, '0, '0);
      else        step(0, 0, '0, '0, 1, 0, a, '0);
      chk(tag, last_rd[u], exp);
   endtask

   function automatic logic [11:0] rand_addr();
      int s = $urandom_range(0, 9);
      int n = $urandom_range(0, 7);
      case (s)
         0: return $urandom_range(0, 1) ? 12'h004 : 12'h000;
         1: return 12'h040;
         2: return 12'h050;
         3: return $urandom_range(0, 1) ? 12'h070 : 12'h060;
         4: return 12'h100 + 12'(4 * n);
         5: return 12'h140 + 12'(4 * n);
         9: return $urandom_range(0, 1) ? 12'h041 : 12'h008;
         default: return 12'h180 + 12'(4 * n);
      endcase
   endfunction

   initial begin
      for (int n = 0; n < 8; n++) begin
         m_rx[n] = 0; m_tx[n] = 0; m_hd[n] = 0; m_cnt[n] = 0;
         for (int k = 0; k < 4; k++) m_mem[n][k] = '0;
      end
      for (int u = 0; u < 2; u++) begin m_en[u] = '0; m_st[u] = '0; last_rd[u] = '0; end
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;

      // R1 reset state
      chk("R1 irq0", 32'(u0_irq), 0);
      chk("R1 irq1", 32'(u1_irq), 0);
      rdx(0, 12'h000, 32'h0, "R1");
      rdx(1, 12'h144, 32'h0, "R1");
      rdx(0, 12'h104, 32'h0, "R1");
      rdx(1, 12'h050, 32'h0, "R1");
      rdx(0, 12'h040, 32'h0, "R1");

      // R2 direction setup
      wr(0, 12'h000, 32'h01100110);
      wr(0, 12'h004, 32'h01100110);
      rdx(1, 12'h004, 32'h01100110, "R2");
      wr(1, 12'h000, 32'hFFFFFFFF);
      rdx(0, 12'h000, 32'h11111111, "R2");
      wr(1, 12'h000, 32'h01100110);

      // R3 fill channel 1 (user 0 -> user 1), fifth push rejected
      for (int k = 0; k < 5; k++) wr(0, 12'h184, 32'hA000_0000 + 32'(k));
      rdx(1, 12'h104, 32'h1, "R5");
      rdx(0, 12'h144, 32'h4, "R5");
      rdx(1, 12'h144, 32'h4, "R3");
      wr(1, 12'h184, 32'hDEAD0001);
      rdx(0, 12'h144, 32'h4, "R3");
      wr(0, 12'h180, 32'hDEAD0002);
      rdx(1, 12'h140, 32'h0, "R3");

      // R6 receive pending, R9 peer view
      rdx(1, 12'h050, 32'h4, "R6");
      rdx(0, 12'h070, 32'h4, "R9");
      wr(1, 12'h050, 32'h4);
      rdx(1, 12'h050, 32'h4, "R6");
      rdx(0, 12'h184, 32'h0, "R4");

      // R10 push to full channel with same-cycle pop
      step(1, 1, 12'h184, 32'hA000_0005, 1, 0, 12'h184, '0);
      chk("R10", last_rd[1], 32'hA000_0000);
      rdx(0, 12'h144, 32'h3, "R10");
      wr(0, 12'h184, 32'hA000_0006);
      rdx(1, 12'h184, 32'hA000_0001, "R4");
      rdx(1, 12'h184, 32'hA000_0002, "R4");
      rdx(1, 12'h184, 32'hA000_0003, "R4");
      rdx(1, 12'h184, 32'hA000_0006, "R4");
      rdx(1, 12'h184, 32'h0, "R4");
      rdx(1, 12'h144, 32'h0, "R4");

      // R7 transmit bit
      rdx(0, 12'h050, 32'h8, "R7");
      wr(0, 12'h050, 32'h8);
      rdx(0, 12'h050, 32'h0, "R7");

      // R6 sticky after drain, ack seen by sender
      rdx(1, 12'h050, 32'h4, "R6");
      wr(1, 12'h050, 32'h4);
      rdx(0, 12'h070, 32'h0, "R9");

      // R8 enable and interrupt line
      wr(1, 12'h040, 32'h4);
      wr(0, 12'h184, 32'hB0B0B0B0);
      chk("R8", 32'(u1_irq), 32'h1);
      wr(1, 12'h040, 32'h0);
      chk("R8", 32'(u1_irq), 32'h0);
      rdx(0, 12'h060, 32'h0, "R9");
      wr(0, 12'h070, 32'hFFFF);
      rdx(1, 12'h050, 32'h4, "R9");
      wr(0, 12'h060, 32'hFFFF);
      rdx(1, 12'h040, 32'h0, "R9");

      // R12 misaligned access
      rdx(1, 12'h052, 32'h0, "R12");
      wr(1, 12'h041, 32'hFFFF);
      rdx(1, 12'h040, 32'h0, "R12");

      // R11 simultaneous direction writes
      step(1, 1, 12'h000, 32'h11111111, 1, 1, 12'h000, 32'h00000000);
      rdx(0, 12'h000, 32'h0, "R11");
      wr(0, 12'h000, 32'h01100110);

      // random traffic on both ports
      for (int i = 0; i < 4000; i++) begin
         bit v0, v1, w0, w1;
         v0 = ($urandom_range(0, 99) < 70);
         v1 = ($urandom_range(0, 99) < 70);
         w0 = $urandom_range(0, 1);
         w1 = $urandom_range(0, 1);
         step(v0, w0, rand_addr(), $urandom(), v1, w1, rand_addr(), $urandom());
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule